// File: doc/BRIEF.md
# Connection Signaling State Engine

This block tracks the lifecycle of a set of point-to-point connections at one switch. Each connection is in one of four states (Closed, Setup-Sent, Established, Release-Sent), and all of them are held in a table indexed by the connection reference. Messages arrive one at a time, already parsed into a type, a reference, a hop limit and a checksum-good flag. A single sequencer handles each one. It checks the message, reads the connection's state and runs the state transition. It issues the side-effect requests for the message type in a fixed order, writes the state back, and then either forwards the message type downstream or raises an error.

The tables that hold routes, bandwidth, interface mappings, references, timeslots and label maps sit outside the block. The engine reaches them through one request port that carries an operation code and a reference. The surrounding logic answers with a same-cycle accept flag. A Setup does not carry a reference: the engine gives it the lowest-numbered Closed entry.

Top module: `conn_sig_engine`

## Requirements
- R1: After reset every connection is Closed, `msg_ready` is high and `op_valid`, `out_valid` and `err` are low.
- R2: Message type codes on `msg_type` and `out_type` are 0 Setup, 1 Setup-Success, 2 Release, 3 Release-Confirm. A forwarded message carries the type of the message that caused it.
- R3: A valid Setup takes the lowest-indexed Closed connection. It issues, one per cycle and with that index on `op_ref`, the requests route lookup (0), bandwidth reserve (1), interface map (2), reference allocate (3), timeslot allocate (4) and label-map program (5). It then forwards a Setup with `out_ref` equal to the index and leaves the connection Setup-Sent.
- R4: A Setup-Success for a Setup-Sent connection issues no request, forwards Setup-Success and moves the connection to Established.
- R5: A Release for an Established connection issues one resource-free request (6), forwards Release and moves the connection to Release-Sent. `op_ok` is ignored on this request.
- R6: A Release-Confirm for a Release-Sent connection issues one reference-free request (7), forwards Release-Confirm and returns the connection to Closed, so that it can be allocated again. `op_ok` is ignored on this request.
- R7: A message with `msg_csum_ok` low pulses `err`, issues no request, forwards nothing and leaves every state unchanged.
- R8: A Setup with a hop limit of zero pulses `err`, issues no request and allocates nothing.
- R9: A Setup-Success, Release or Release-Confirm whose connection is not in the state it needs pulses `err`, issues no request and leaves the state unchanged.
- R10: If `op_ok` is low on any Setup request (codes 0 to 5), that request is the last one issued. `err` pulses and the connection stays Closed.
- R11: A Setup while no connection is Closed pulses `err` and issues no request.
- R12: `out_valid` and `err` are one-cycle pulses that never coincide. `msg_ready` is low while requests are being issued. A message accepted in the write-back cycle of the previous one sees that message's state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Engine can take a message this cycle |
| msg_type | input | 2 | Incoming message type |
| msg_ref | input | REF_W | Connection reference (ignored for Setup) |
| msg_ttl | input | TTL_W | Hop limit |
| msg_csum_ok | input | 1 | Checksum of the message was good |
| op_valid | output | 1 | Side-effect request issued |
| op_code | output | 3 | Request kind, codes 0 to 7 as in R3, R5 and R6 |
| op_ref | output | REF_W | Connection the request concerns |
| op_ok | input | 1 | Same-cycle accept for the request |
| out_valid | output | 1 | Outgoing message pulse |
| out_type | output | 2 | Outgoing message type |
| out_ref | output | REF_W | Connection of the outgoing message |
| err | output | 1 | Message rejected pulse |

## Verification
Two things can happen in the same cycle: the table write-back of one message and the acceptance of the next. The bench first fills the table. It then holds a Setup on the input while a Release-Confirm frees one entry, so the Setup is taken in the Release-Confirm's write-back cycle. The bench passes this case if the Setup gets the index that was just freed, since that index is the only Closed entry. Long deterministic pseudo-random message streams, checked against an arithmetic model of the table, also produce many back-to-back accept and write-back cycles.

// File: rtl/conn_sig_pkg.sv
package conn_sig_pkg;
  typedef enum logic [1:0] {
    MSG_SETUP = 2'd0,
    MSG_OK    = 2'd1,
    MSG_REL   = 2'd2,
    MSG_RELCF = 2'd3
  } msg_t;

  typedef enum logic [1:0] {
    ST_CLOSED     = 2'd0,
    ST_SETUP_SENT = 2'd1,
    ST_ESTAB      = 2'd2,
    ST_REL_SENT   = 2'd3
  } cst_t;

  typedef enum logic [2:0] {
    OP_ROUTE      = 3'd0,
    OP_BW_RSV     = 3'd1,
    OP_IF_MAP     = 3'd2,
    OP_REF_ALLOC  = 3'd3,
    OP_SLOT_ALLOC = 3'd4,
    OP_LABEL_PROG = 3'd5,
    OP_RES_FREE   = 3'd6,
    OP_REF_FREE   = 3'd7
  } op_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CHECK = 2'd1,
    S_STEP  = 2'd2,
    S_WB    = 2'd3
  } seq_t;
endpackage

// File: rtl/conn_rst_sync.sv
module conn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/conn_state_table.sv
module conn_state_table
  import conn_sig_pkg::*;
#(
  parameter int NCONN = 16,
  parameter int REF_W = $clog2(NCONN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REF_W-1:0] wr_ref,
  input  cst_t             wr_state,
  input  logic [REF_W-1:0] rd_ref,
  output cst_t             rd_state,
  output logic [REF_W-1:0] free_ref,
  output logic             free_any
);
  cst_t tbl_q [NCONN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCONN; i++) tbl_q[i] <= ST_CLOSED;
    end else if (wr_en) begin
      tbl_q[wr_ref] <= wr_state;
    end
  end

  assign rd_state = tbl_q[rd_ref];

  // lowest-indexed Closed entry
  always_comb begin
    free_ref = '0;
    free_any = 1'b0;
    for (int i = NCONN - 1; i >= 0; i--) begin
      if (tbl_q[i] == ST_CLOSED) begin
        free_ref = REF_W'(i);
        free_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/conn_seq.sv
module conn_seq
  import conn_sig_pkg::*;
#(
  parameter int REF_W = 4,
  parameter int TTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  msg_t             msg_type,
  input  logic [REF_W-1:0] msg_ref,
  input  logic [TTL_W-1:0] msg_ttl,
  input  logic             msg_csum_ok,
  output logic [REF_W-1:0] rd_ref,
  input  cst_t             rd_state,
  input  logic [REF_W-1:0] free_ref,
  input  logic             free_any,
  output logic             wr_en,
  output logic [REF_W-1:0] wr_ref,
  output cst_t             wr_state,
  output logic             op_valid,
  output op_t              op_code,
  output logic [REF_W-1:0] op_ref,
  input  logic             op_ok,
  output logic             out_valid,
  output msg_t             out_type,
  output logic [REF_W-1:0] out_ref,
  output logic             err
);
  seq_t             seq_q, seq_d;
  msg_t             type_q, type_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic [TTL_W-1:0] ttl_q, ttl_d;
  logic             csum_q, csum_d;
  op_t              step_q, step_d;
  cst_t             nst_q, nst_d;
  logic             err_q, err_d;
  logic             accept, bad, reserving;
  cst_t             need_st, goal_st;

  assign msg_ready = (seq_q == S_IDLE) || (seq_q == S_WB);
  assign accept    = msg_valid && msg_ready;
  assign rd_ref    = (type_q == MSG_SETUP) ? free_ref : ref_q;
  assign reserving = (step_q <= OP_LABEL_PROG);

  always_comb begin
    unique case (type_q)
      MSG_SETUP: begin need_st = ST_CLOSED;     goal_st = ST_SETUP_SENT; end
      MSG_OK:    begin need_st = ST_SETUP_SENT; goal_st = ST_ESTAB;      end
      MSG_REL:   begin need_st = ST_ESTAB;      goal_st = ST_REL_SENT;   end
      default:   begin need_st = ST_REL_SENT;   goal_st = ST_CLOSED;     end
    endcase
    bad = !csum_q || (rd_state != need_st) ||
          ((type_q == MSG_SETUP) && ((ttl_q == '0) || !free_any));
  end

  always_comb begin
    seq_d  = seq_q;
    type_d = type_q;
    ref_d  = ref_q;
    ttl_d  = ttl_q;
    csum_d = csum_q;
    step_d = step_q;
    nst_d  = nst_q;
    err_d  = err_q;
    unique case (seq_q)
      S_IDLE, S_WB: begin
        if (accept) begin
          type_d = msg_type;
          ref_d  = msg_ref;
          ttl_d  = msg_ttl;
          csum_d = msg_csum_ok;
          err_d  = 1'b0;
          seq_d  = S_CHECK;
        end else begin
          seq_d  = S_IDLE;
        end
      end
      S_CHECK: begin
        ref_d = rd_ref;
        err_d = bad;
        nst_d = bad ? rd_state : goal_st;
        if (bad || (type_q == MSG_OK)) begin
          seq_d = S_WB;
        end else begin
          seq_d = S_STEP;
          unique case (type_q)
            MSG_SETUP: step_d = OP_ROUTE;
            MSG_REL:   step_d = OP_RES_FREE;
            default:   step_d = OP_REF_FREE;
          endcase
        end
      end
      default: begin
        if (reserving && !op_ok) begin
          err_d = 1'b1;
          nst_d = ST_CLOSED;
          seq_d = S_WB;
        end else if ((step_q == OP_LABEL_PROG) || !reserving) begin
          seq_d = S_WB;
        end else begin
          step_d = op_t'(step_q + 3'd1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= S_IDLE;
      type_q <= MSG_SETUP;
      ref_q  <= '0;
      ttl_q  <= '0;
      csum_q <= 1'b0;
      step_q <= OP_ROUTE;
      nst_q  <= ST_CLOSED;
      err_q  <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      type_q <= type_d;
      ref_q  <= ref_d;
      ttl_q  <= ttl_d;
      csum_q <= csum_d;
      step_q <= step_d;
      nst_q  <= nst_d;
      err_q  <= err_d;
    end
  end

  assign op_valid  = (seq_q == S_STEP);
  assign op_code   = step_q;
  assign op_ref    = ref_q;
  assign wr_en     = (seq_q == S_WB);
  assign wr_ref    = ref_q;
  assign wr_state  = nst_q;
  assign out_valid = (seq_q == S_WB) && !err_q;
  assign err       = (seq_q == S_WB) && err_q;
  assign out_type  = type_q;
  assign out_ref   = ref_q;
endmodule

// File: rtl/conn_sig_engine.sv
module conn_sig_engine
  import conn_sig_pkg::*;
#(
  parameter int NCONN = 16,
  parameter int TTL_W = 8,
  localparam int REF_W = $clog2(NCONN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [1:0]       msg_type,
  input  logic [REF_W-1:0] msg_ref,
  input  logic [TTL_W-1:0] msg_ttl,
  input  logic             msg_csum_ok,
  output logic             op_valid,
  output logic [2:0]       op_code,
  output logic [REF_W-1:0] op_ref,
  input  logic             op_ok,
  output logic             out_valid,
  output logic [1:0]       out_type,
  output logic [REF_W-1:0] out_ref,
  output logic             err
);
  logic             rst_sn;
  logic [REF_W-1:0] rd_ref, free_ref, wr_ref;
  cst_t             rd_state, wr_state;
  logic             free_any, wr_en;
  op_t              op_code_e;
  msg_t             out_type_e;

  conn_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .arst_n(rst_n), .rst_sn(rst_sn)
  );

  conn_state_table #(.NCONN(NCONN), .REF_W(REF_W)) i_table (
    .clk(clk), .rst_n(rst_sn),
    .wr_en(wr_en), .wr_ref(wr_ref), .wr_state(wr_state),
    .rd_ref(rd_ref), .rd_state(rd_state),
    .free_ref(free_ref), .free_any(free_any)
  );

  conn_seq #(.REF_W(REF_W), .TTL_W(TTL_W)) i_seq (
    .clk(clk), .rst_n(rst_sn),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_type(msg_t'(msg_type)), .msg_ref(msg_ref),
    .msg_ttl(msg_ttl), .msg_csum_ok(msg_csum_ok),
    .rd_ref(rd_ref), .rd_state(rd_state),
    .free_ref(free_ref), .free_any(free_any),
    .wr_en(wr_en), .wr_ref(wr_ref), .wr_state(wr_state),
    .op_valid(op_valid), .op_code(op_code_e), .op_ref(op_ref), .op_ok(op_ok),
    .out_valid(out_valid), .out_type(out_type_e), .out_ref(out_ref), .err(err)
  );

  assign op_code  = op_code_e;
  assign out_type = out_type_e;
endmodule

// File: rtl/conn_sig_engine_chk.sv
module conn_sig_engine_chk #(
  parameter int REF_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_ready,
  input logic             op_valid,
  input logic [2:0]       op_code,
  input logic [REF_W-1:0] op_ref,
  input logic             op_ok,
  input logic             out_valid,
  input logic             err
);
  // R12: outcome pulses never coincide
  p_out_err_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && err));

  // R12: no intake and no outcome while a request is out
  p_busy_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (!msg_ready && !out_valid && !err));

  // R12: an outcome lasts one cycle
  p_out_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || err) |=> !(out_valid || err));

  // R3: accepted Setup requests advance one code per cycle
  p_op_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code < 3'd5) && op_ok) |=>
      (op_valid && (op_code == $past(op_code) + 3'd1)));

  // R3: the reference stays fixed across a request run
  p_op_ref_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && $past(op_valid)) |-> $stable(op_ref));

  // R10: a refused Setup request ends the run with an error
  p_refuse_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code <= 3'd5) && !op_ok) |=> (!op_valid && err));

  // R5 / R6: a free request is single and always completes
  p_free_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code >= 3'd6)) |=> (!op_valid && out_valid));
endmodule

bind conn_sig_engine conn_sig_engine_chk #(.REF_W(REF_W)) i_chk (
  .clk(clk), .rst_n(rst_sn), .msg_ready(msg_ready),
  .op_valid(op_valid), .op_code(op_code), .op_ref(op_ref), .op_ok(op_ok),
  .out_valid(out_valid), .err(err)
);

// File: tb/test_conn_sig_engine.sv
`timescale 1ns/1ps
module test_conn_sig_engine;
  localparam int NC = 16;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic msg_valid, msg_ready, msg_csum_ok;
  logic [1:0] msg_type;
  logic [RW-1:0] msg_ref;
  logic [7:0] msg_ttl;
  logic op_valid, op_ok, out_valid, err;
  logic [2:0] op_code;
  logic [RW-1:0] op_ref, out_ref;
  logic [1:0] out_type;

  int refuse_code;
  assign op_ok = !(op_valid && (int'(op_code) == refuse_code));

  always #2.5 clk = ~clk;

  conn_sig_engine #(.NCONN(NC), .TTL_W(8)) i_conn_sig_engine (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
    .msg_ref(msg_ref), .msg_ttl(msg_ttl), .msg_csum_ok(msg_csum_ok),
    .op_valid(op_valid), .op_code(op_code), .op_ref(op_ref), .op_ok(op_ok),
    .out_valid(out_valid), .out_type(out_type), .out_ref(out_ref), .err(err)
  );

  int n_chk, n_fail;
  bit done;
  int model [NC];

  int a_op_n, a_ev_n, e_op_n, e_ev_n;
  int a_op [64];
  int a_oref [64];
  int a_ev_err [64];
  int a_ev_type [64];
  int a_ev_ref [64];
  int e_op [64];
  int e_oref [64];
  string e_op_tag [64];
  int e_ev_err [64];
  int e_ev_type [64];
  int e_ev_ref [64];
  string e_ev_tag [64];

  always @(negedge clk) begin
    if (op_valid && a_op_n < 64) begin
      a_op[a_op_n] = int'(op_code);
      a_oref[a_op_n] = int'(op_ref);
      a_op_n++;
    end
    if ((out_valid || err) && a_ev_n < 64) begin
      a_ev_err[a_ev_n] = int'(err);
      a_ev_type[a_ev_n] = int'(out_type);
      a_ev_ref[a_ev_n] = int'(out_ref);
      a_ev_n++;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic add_op(input int code, input int r, input string tag);
    e_op[e_op_n] = code; e_oref[e_op_n] = r; e_op_tag[e_op_n] = tag; e_op_n++;
  endtask

  task automatic add_ev(input int e, input int t, input int r, input string tag);
    e_ev_err[e_ev_n] = e; e_ev_type[e_ev_n] = t; e_ev_ref[e_ev_n] = r;
    e_ev_tag[e_ev_n] = tag; e_ev_n++;
  endtask

  task automatic predict(input int t, input int r, input int ttl, input bit ck);
    if (t == 0) begin
      int found = -1;
      for (int i = NC - 1; i >= 0; i--) if (model[i] == 0) found = i;
      if (!ck) add_ev(1, 0, -1, "R7");
      else if (ttl == 0) add_ev(1, 0, -1, "R8");
      else if (found < 0) add_ev(1, 0, -1, "R11");
      else if (refuse_code >= 0 && refuse_code <= 5) begin
        for (int k = 0; k <= refuse_code; k++) add_op(k, found, "R10");
        add_ev(1, 0, found, "R10");
      end else begin
        for (int k = 0; k < 6; k++) add_op(k, found, "R3");
        add_ev(0, 0, found, "R3");
        model[found] = 1;
      end
    end else begin
      if (!ck) add_ev(1, t, r, "R7");
      else if (model[r] != t) add_ev(1, t, r, "R9");
      else begin
        if (t == 1) begin add_ev(0, 1, r, "R4"); model[r] = 2; end
        else if (t == 2) begin add_op(6, r, "R5"); add_ev(0, 2, r, "R5"); model[r] = 3; end
        else begin add_op(7, r, "R6"); add_ev(0, 3, r, "R6"); model[r] = 0; end
      end
    end
  endtask

  task automatic issue(input int t, input int r, input int ttl, input bit ck);
    bit rdy;
    predict(t, r, ttl, ck);
    @(negedge clk);
    msg_valid = 1'b1; msg_type = 2'(t); msg_ref = RW'(r);
    msg_ttl = 8'(ttl); msg_csum_ok = ck;
    forever begin
      rdy = msg_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    #1 msg_valid = 1'b0;
  endtask

  task automatic ep_begin();
    a_op_n = 0; a_ev_n = 0; e_op_n = 0; e_ev_n = 0;
  endtask

  task automatic ep_end();
    int w = 0;
    while (a_ev_n < e_ev_n && w < 200) begin @(negedge clk); w++; end
    repeat (2) @(negedge clk);
    check("R12", "outcome count", a_ev_n, e_ev_n);
    check("R12", "request count", a_op_n, e_op_n);
    for (int i = 0; i < e_ev_n && i < a_ev_n; i++) begin
      check(e_ev_tag[i], "err flag", a_ev_err[i], e_ev_err[i]);
      check("R2", "out_type", a_ev_type[i], e_ev_type[i]);
      if (e_ev_ref[i] >= 0) check(e_ev_tag[i], "out_ref", a_ev_ref[i], e_ev_ref[i]);
    end
    for (int i = 0; i < e_op_n && i < a_op_n; i++) begin
      check(e_op_tag[i], "op_code", a_op[i], e_op[i]);
      check(e_op_tag[i], "op_ref", a_oref[i], e_oref[i]);
    end
  endtask

  task automatic one(input int t, input int r, input int ttl, input bit ck, input int rf);
    refuse_code = rf;
    ep_begin();
    issue(t, r, ttl, ck);
    ep_end();
    refuse_code = -1;
  endtask

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    n_chk = 0; n_fail = 0; done = 0; refuse_code = -1;
    msg_valid = 0; msg_type = 0; msg_ref = 0; msg_ttl = 0; msg_csum_ok = 0;
    a_op_n = 0; a_ev_n = 0; e_op_n = 0; e_ev_n = 0;
    for (int i = 0; i < NC; i++) model[i] = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1", "msg_ready", int'(msg_ready), 1);
    check("R1", "op_valid", int'(op_valid), 0);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "err", int'(err), 0);

    // R7, R8 before any allocation: nothing taken, next Setup still gets 0
    one(0, 0, 5, 1'b0, -1);
    one(0, 0, 0, 1'b1, -1);
    // R10 refusal at each Setup step, connection 0 stays Closed
    for (int k = 0; k < 6; k++) one(0, 0, 5, 1'b1, k);
    // R3 fill whole table with lowest-index allocation
    for (int i = 0; i < NC; i++) one(0, 0, 7, 1'b1, -1);
    // R11 table full
    one(0, 0, 7, 1'b1, -1);
    // R9 wrong-state sweep on connection 5 (Setup-Sent), R4 R5 R6 progress
    one(2, 5, 1, 1'b1, -1);
    one(3, 5, 1, 1'b1, -1);
    one(1, 5, 1, 1'b0, -1);
    one(1, 5, 1, 1'b1, -1);
    one(1, 5, 1, 1'b1, -1);
    one(3, 5, 1, 1'b1, -1);
    one(2, 5, 1, 1'b1, 6);
    one(2, 5, 1, 1'b1, -1);
    one(1, 5, 1, 1'b1, -1);
    one(3, 5, 1, 1'b1, 7);
    one(1, 5, 1, 1'b1, -1);
    // R6 freed entry reused by next Setup
    one(0, 0, 3, 1'b1, -1);

    // R12 back-to-back: Release-Confirm write-back and Setup intake share a cycle
    one(1, 9, 1, 1'b1, -1);
    one(2, 9, 1, 1'b1, -1);
    ep_begin();
    issue(3, 9, 1, 1'b1);
    issue(0, 0, 4, 1'b1);
    ep_end();
    check("R12", "Setup after same-cycle free gets index", (a_ev_n > 1) ? a_ev_ref[1] : -1, 9);

    // pseudo-random stream over all types, states and faults
    lf = 16'hACE1;
    for (int n = 0; n < 2500; n++) begin
      int t, r, ttl, rf;
      bit ck;
      lf = lfsr_step(lf); lf = lfsr_step(lf); lf = lfsr_step(lf);
      t = int'(lf[1:0]); r = int'(lf[5:2]);
      ck = (lf[8:6] != 3'd0);
      ttl = (lf[11:9] == 3'd0) ? 0 : int'(lf[11:9]);
      lf = lfsr_step(lf); lf = lfsr_step(lf); lf = lfsr_step(lf);
      rf = (lf[3:0] == 4'd0) ? int'(lf[6:4]) : -1;
      if (n % 2 == 1) begin
        // chained pair to provoke intake in the write-back cycle
        ep_begin();
        refuse_code = -1;
        issue(t, r, ttl, ck);
        issue(int'(lf[9:8]), int'(lf[13:10]), 3, 1'b1);
        ep_end();
      end else begin
        one(t, r, ttl, ck, rf);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule